// File: doc/BRIEF.md
# Integer Add Unit with Carry and Overflow Flags

This block is the addition slice of a simple RISC execute stage. Each cycle in which `in_valid` is high it accepts a 2-bit opcode, two register operands, a 16-bit immediate, the current carry flag and an overflow-trap enable taken from the status register. It adds the first register to either the second register or the sign-extended immediate. For the two carry opcodes it also adds the incoming carry flag.

One clock later it presents the 32-bit sum, the new carry flag, the new signed-overflow flag and a single-cycle range-exception request, all registered together and marked by `out_valid`. Both flags come from the complete sum, carry-in included. Only signed overflow can raise the exception, and only when the enable is set. The sum and flags are presented even in a cycle that requests an exception. The consumer decides whether to suppress writeback.

Operand fetch, writeback, the status register itself and exception vectoring belong to neighbouring logic.

Top module: `iadd_flags`

## Requirements
- R1: Opcode 2'b00 (register add) produces `src_a + src_b` modulo 2^32, and `carry_flag_in` has no effect on the sum or on either flag.
- R2: Opcode 2'b01 (register add with carry) produces `src_a + src_b + carry_flag_in` modulo 2^32.
- R3: Opcode 2'b10 (immediate add) produces `src_a` plus `imm` sign-extended from bit 15, so 0x8000 counts as 0xFFFF8000. `src_b` and `carry_flag_in` have no effect.
- R4: Opcode 2'b11 (immediate add with carry) produces `src_a` plus the sign-extended `imm` plus `carry_flag_in`. `src_b` has no effect.
- R5: `carry_out` is the unsigned carry out of bit 31 of the full sum, carry-in included. For example, 0xFFFFFFFF + 0 + 1 gives 0 with carry 1, in either operand order.
- R6: `ovf_out` is set exactly when the full signed sum, carry-in included, falls outside [-2^31, 2^31-1]. So a carry-in can create an overflow (0x40000000+0x3FFFFFFF+1), and it can also cancel one (0xC0000000+0xBFFFFFFF+1).
- R7: When `ovf_exc_en` is high, an operation that sets `ovf_out` raises `range_exc`, whether or not carry is also set. A carry with no overflow never raises it.
- R8: When `ovf_exc_en` is low, `range_exc` stays low, and `carry_out` and `ovf_out` are still updated.
- R9: Results appear on the clock edge after `in_valid`, with `out_valid` high for that one cycle. `range_exc` is a one-cycle pulse that coincides with the result.
- R10: While `in_valid` is low, `sum_out`, `carry_out` and `ovf_out` hold their last values, and `out_valid` and `range_exc` are low.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Bit 0 adds the carry flag; bit 1 selects the immediate |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate, sign-extended |
| carry_flag_in | input | 1 | Current carry flag |
| ovf_exc_en | input | 1 | Overflow-trap enable |
| out_valid | output | 1 | Result valid, one cycle |
| sum_out | output | 32 | Registered sum |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |
| range_exc | output | 1 | Range-exception request pulse |

## Verification
Uniform random operands almost never produce the operand sets where the carry-in alone decides the flags. These are all-ones plus zero plus one, and operand pairs one unit away from overflow, where the carry-in either crosses the signed limit or pulls the sum back inside it. The stimulus therefore mixes a directed list of these boundary operands, for both carry opcodes and both operand orders, with random vectors. Each random vector has a one-in-four chance of drawing its operands from values next to 0x7FFFFFFF, 0x80000000, 0xBFFFFFFF and 0xFFFFFFFF. The enable and the incoming carry flag are toggled independently, so the case of carry and overflow together under the enable is reached often.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    localparam int DATA_W     = 32;
    localparam int IMM_W      = 16;
    localparam int OP_W       = 2;
    // Opcode bit meanings; the operand selector decodes these positions.
    localparam int OP_CY_BIT  = 0;
    localparam int OP_IMM_BIT = 1;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 2'b00,
        OP_ADDC  = 2'b01,
        OP_ADDI  = 2'b10,
        OP_ADDIC = 2'b11
    } add_op_e;

endpackage

// File: rtl/iadd_opsel.sv
module iadd_opsel
    import iadd_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int I_W = IMM_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [D_W-1:0]  src_b,
    input  logic [I_W-1:0]  imm,
    input  logic            carry_flag_in,
    output logic [D_W-1:0]  b_eff,
    output logic            c_eff
);
    localparam int EXT_W = D_W - I_W;

    logic [D_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[I_W-1]}}, imm};
        b_eff   = op[OP_IMM_BIT] ? imm_ext : src_b;
        c_eff   = op[OP_CY_BIT] & carry_flag_in;
    end
endmodule

// File: rtl/iadd_adder.sv
module iadd_adder #(
    parameter int D_W   = 32,
    parameter int SEG_W = 8
) (
    input  logic [D_W-1:0] a,
    input  logic [D_W-1:0] b,
    input  logic           c_in,
    output logic [D_W-1:0] sum,
    output logic           c_out,
    output logic           ovf
);
    localparam int NSEG = (SEG_W >= D_W) ? 1 : D_W / SEG_W;
    localparam int MSB  = D_W - 1;

    generate
        if (SEG_W >= D_W) begin : g_flat
            assign {c_out, sum} = {1'b0, a} + {1'b0, b} + {{D_W{1'b0}}, c_in};
        end else begin : g_seg
            logic [NSEG:0] chain;
            assign chain[0] = c_in;
            for (genvar g = 0; g < NSEG; g++) begin : g_blk
                assign {chain[g+1], sum[g*SEG_W +: SEG_W]} =
                    {1'b0, a[g*SEG_W +: SEG_W]} + {1'b0, b[g*SEG_W +: SEG_W]}
                    + {{SEG_W{1'b0}}, chain[g]};
            end
            assign c_out = chain[NSEG];
        end
    endgenerate

    // Signed overflow: like-signed operands yield an unlike-signed sum.
    assign ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/iadd_flags.sv
module iadd_flags
    import iadd_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int I_W   = IMM_W,
    parameter int SEG_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [D_W-1:0]  src_a,
    input  logic [D_W-1:0]  src_b,
    input  logic [I_W-1:0]  imm,
    input  logic            carry_flag_in,
    input  logic            ovf_exc_en,
    output logic            out_valid,
    output logic [D_W-1:0]  sum_out,
    output logic            carry_out,
    output logic            ovf_out,
    output logic            range_exc
);
    typedef struct packed {
        logic           vld;
        logic [D_W-1:0] sum;
        logic           cy;
        logic           ov;
        logic           exc;
    } res_t;

    localparam res_t RES_RST = '0;

    logic [D_W-1:0] b_eff;
    logic           c_eff;
    logic [D_W-1:0] add_sum;
    logic           add_cy;
    logic           add_ov;
    res_t           res_d;
    res_t           res_q;

    iadd_opsel #(.D_W(D_W), .I_W(I_W)) opsel_i (
        .op            (op),
        .src_b         (src_b),
        .imm           (imm),
        .carry_flag_in (carry_flag_in),
        .b_eff         (b_eff),
        .c_eff         (c_eff)
    );

    iadd_adder #(.D_W(D_W), .SEG_W(SEG_W)) adder_i (
        .a     (src_a),
        .b     (b_eff),
        .c_in  (c_eff),
        .sum   (add_sum),
        .c_out (add_cy),
        .ovf   (add_ov)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        res_d.exc = 1'b0;
        if (in_valid) begin
            res_d.sum = add_sum;
            res_d.cy  = add_cy;
            res_d.ov  = add_ov;
            res_d.exc = add_ov & ovf_exc_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= RES_RST;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign sum_out   = res_q.sum;
    assign carry_out = res_q.cy;
    assign ovf_out   = res_q.ov;
    assign range_exc = res_q.exc;
endmodule

// File: rtl/iadd_flags_chk.sv
module iadd_flags_chk
    import iadd_pkg::*;
#(
    parameter int D_W = DATA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] op,
    input logic [D_W-1:0]  src_a,
    input logic [D_W-1:0]  src_b,
    input logic            ovf_exc_en,
    input logic            out_valid,
    input logic [D_W-1:0]  sum_out,
    input logic            ovf_out,
    input logic            range_exc
);
    // R1
    reg_add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00) |=> (sum_out == D_W'($past(src_a) + $past(src_b))));
    // R7
    exc_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc |-> (ovf_out && out_valid));
    // R8
    exc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ovf_exc_en) |=> !range_exc);
    // R9
    result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !range_exc && $stable(sum_out)));
endmodule

bind iadd_flags iadd_flags_chk #(.D_W(D_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op         (op),
    .src_a      (src_a),
    .src_b      (src_b),
    .ovf_exc_en (ovf_exc_en),
    .out_valid  (out_valid),
    .sum_out    (sum_out),
    .ovf_out    (ovf_out),
    .range_exc  (range_exc)
);

// File: tb/iadd_flags_tb.sv
module iadd_flags_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic        carry_flag_in = 1'b0;
    logic        ovf_exc_en = 1'b0;
    logic        out_valid;
    logic [31:0] sum_out;
    logic        carry_out;
    logic        ovf_out;
    logic        range_exc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iadd_flags dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .carry_flag_in(carry_flag_in), .ovf_exc_en(ovf_exc_en),
        .out_valid(out_valid), .sum_out(sum_out), .carry_out(carry_out),
        .ovf_out(ovf_out), .range_exc(range_exc)
    );

    // Expected {exc, ov, cy, sum}, from the requirement text.
    function automatic logic [34:0] expect_of(input logic [1:0] o,
            input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
            input logic ci, input logic en);
        logic [31:0]        opb;
        logic               c;
        logic [32:0]        u;
        logic signed [33:0] s;
        logic               ov;
        opb = o[1] ? {{16{im[15]}}, im} : b;
        c   = o[0] ? ci : 1'b0;
        u   = {1'b0, a} + {1'b0, opb} + {32'd0, c};
        s   = $signed({{2{a[31]}}, a}) + $signed({{2{opb[31]}}, opb}) + $signed({33'd0, c});
        ov  = (s > 34'sd2147483647) || (s < -34'sd2147483648);
        return {en & ov, ov, u[32], u[31:0]};
    endfunction

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got {vld,exc,ov,cy,sum}=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] o, input logic [31:0] a,
            input logic [31:0] b, input logic [15:0] im, input logic ci, input logic en);
        logic [34:0] e;
        logic [31:0] held;
        e = expect_of(o, a, b, im, ci, en);
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b; imm = im;
        carry_flag_in = ci; ovf_exc_en = en;
        @(negedge clk);
        in_valid = 1'b0;
        // scramble idle inputs: must not disturb held outputs (R10)
        src_a = ~a; src_b = ~b; carry_flag_in = ~ci;
        check(tag, {out_valid, range_exc, ovf_out, carry_out, sum_out}, {1'b1, e});
        held = sum_out;
        @(negedge clk);
        // R9 pulse ends, R10 hold
        check("R9/R10 idle", {out_valid, range_exc, ovf_out, carry_out, sum_out},
              {1'b0, 1'b0, e[33], e[32], held});
    endtask

    function automatic string tag_of(input logic [1:0] o);
        case (o)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        logic [31:0] base[4] = '{32'h7FFFFFFF, 32'h80000000, 32'hBFFFFFFF, 32'hFFFFFFFF};
        if ($urandom_range(3) == 0)
            return base[$urandom_range(3)] + 32'($urandom_range(2)) - 32'd1;
        return $urandom;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {out_valid, range_exc, ovf_out, carry_out, sum_out}, 36'd0);
        rst_n = 1'b1;

        // R1 / R3: carry flag ignored
        apply("R1 1+2 cy ignored", 2'b00, 32'd1, 32'd2, 16'h0, 1'b1, 1'b0);
        apply("R3 1+imm2 cy ignored", 2'b10, 32'd1, 32'hDEAD, 16'h0002, 1'b1, 1'b0);
        apply("R3 sext 0xFFFE", 2'b10, 32'hFFFFFFFF, 32'h0, 16'hFFFE, 1'b0, 1'b0);
        apply("R3 sext 0x8000", 2'b10, 32'h80008000, 32'h0, 16'h8000, 1'b0, 1'b0);
        // R5 carry only
        apply("R5 carry no ovf", 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFE, 16'h0, 1'b0, 1'b1);
        apply("R5 all-ones+0+1", 2'b01, 32'hFFFFFFFF, 32'h0, 16'h0, 1'b1, 1'b1);
        apply("R5 0+all-ones+1", 2'b01, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b1, 1'b1);
        apply("R5 R4 0+imm ffff+1", 2'b11, 32'h0, 32'h0, 16'hFFFF, 1'b1, 1'b1);
        apply("R5 R4 all-ones+imm0+1", 2'b11, 32'hFFFFFFFF, 32'h0, 16'h0000, 1'b1, 1'b0);
        // R6 overflow
        apply("R6 pos ovf", 2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 1'b0);
        apply("R6 R7 both flags", 2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 1'b0, 1'b1);
        apply("R6 R2 carry creates ovf", 2'b01, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1'b1, 1'b1);
        apply("R6 R2 carry cancels ovf", 2'b01, 32'hC0000000, 32'hBFFFFFFF, 16'h0, 1'b1, 1'b1);
        apply("R6 R4 carry creates ovf", 2'b11, 32'h7FFF8000, 32'h0, 16'h7FFF, 1'b1, 1'b1);
        apply("R6 R4 carry cancels ovf", 2'b11, 32'h80007FFF, 32'h0, 16'h8000, 1'b1, 1'b1);
        apply("R6 R3 neg ovf", 2'b10, 32'h80007FFF, 32'h0, 16'h8000, 1'b0, 1'b1);
        apply("R2 no carry in", 2'b01, 32'h40000000, 32'h3FFFFFFF, 16'h0, 1'b0, 1'b1);
        // R8 enable cleared, flags still set
        apply("R8 ovf no exc", 2'b00, 32'hBFFFFFFF, 32'hBFFFFFFF, 16'h0, 1'b0, 1'b0);
        // R9 back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; op = 2'b00; src_a = 32'h40000000; src_b = 32'h40000000; ovf_exc_en = 1'b1;
        @(negedge clk);
        src_a = 32'd5; src_b = 32'd6;
        check("R9 b2b first", {out_valid, range_exc, ovf_out, carry_out, sum_out},
              {1'b1, 1'b1, 1'b1, 1'b0, 32'h80000000});
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second exc drops", {out_valid, range_exc, ovf_out, carry_out, sum_out},
              {1'b1, 1'b0, 1'b0, 1'b0, 32'd11});

        for (int i = 0; i < 2000; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(3));
            apply(tag_of(o), o, pick_val(), pick_val(), 16'($urandom),
                  1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R9 got=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule